// File: doc/BRIEF.md
# Two-Byte Register Read Controller for a Two-Wire Bus

This block is the controlling side of a two-wire serial bus (I2C) that fetches 16-bit register contents from a target device. It works in one of two ways. In the first, the target's register pointer is already set, so the block sends the address with the read bit and streams data at once. In the second, it writes an address frame and a pointer byte, then issues a repeated START with no STOP between. It follows this with the address again, now with the read bit, and streams data.

Both bus lines are open drain. The block only pulls a line low, by raising its output enable, and otherwise releases it. A divider splits every bit into four equal quarters. A command pulse starts a transfer with a 7-bit target address, a 3-bit pointer, a pointer-write flag and a word count. Each 16-bit result is presented with a one-cycle valid strobe. The block also reports busy, a done pulse and a sticky flag for a missing acknowledge.

The controller is a single state machine with six states:
- IDLE: both lines released.
- START: SDA falls while SCL is high.
- TX: sends one byte plus the acknowledge clock.
- RX: receives one byte plus the controller's acknowledge clock.
- RESTART: repeated START.
- STOP: SDA rises while SCL is high.

Transitions:
- IDLE→START on an accepted command.
- START→TX, sending the address frame.
- TX→TX from the write-address frame to the pointer byte.
- TX→RESTART after the pointer byte is acknowledged.
- TX→RX after the read-address frame is acknowledged.
- TX→STOP on a missing acknowledge.
- RESTART→TX with the read-address frame.
- RX→RX between bytes and words.
- RX→STOP after the last byte.
- STOP→IDLE.

Top module: `i2c_word_reader`

## Requirements
- R1: Every transfer opens with a START and an address frame: the 7 address bits MSB first, then the direction bit (1 = read, 0 = write), then a ninth clock on which the target acknowledges by holding SDA low.
- R2: With `cmd_ptr_wr` = 0, the only address frame carries direction bit 1, and data bytes follow it directly.
- R3: With `cmd_ptr_wr` = 1, the first address frame carries direction bit 0 and is followed by a pointer byte whose bits 7..3 are zero and whose bits 2..0 are `cmd_ptr`.
- R4: After the pointer byte is acknowledged, a repeated START follows with no STOP in between, then the address frame again with direction bit 1. A pointer transfer therefore shows two STARTs and one STOP.
- R5: Each word arrives as its high byte then its low byte, each MSB first. It is presented on `word_data` with `word_valid` high for exactly one cycle.
- R6: The controller acknowledges the first byte of every word and the second byte of every word but the last. It does not acknowledge the final byte, and STOP follows.
- R7: A transfer delivers `cmd_words` words, with a count of 0 treated as 1. Words are streamed with no further address frame.
- R8: If the target does not acknowledge an address or pointer byte, the controller generates a STOP, returns to idle, delivers no word and sets `nack_err`. `nack_err` stays set until the next accepted command clears it.
- R9: SDA changes only while SCL is low, except for the START, repeated START and STOP conditions. Each SCL level lasts a whole number of quarters, and every bit spans 4×QDIV clock cycles.
- R10: In idle both output enables are low. `busy` is high from the cycle after an accepted command until the return to idle. `done` pulses for one cycle on that return.
- R11: `cmd_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse, taken only when idle |
| cmd_addr | input | 7 | Target address |
| cmd_ptr | input | 3 | Pointer value written in pointer mode |
| cmd_ptr_wr | input | 1 | 1 = write pointer then repeated START, 0 = preset pointer |
| cmd_words | input | WCNT_W | Number of 16-bit words to read (0 reads one) |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| word_data | output | 16 | Last assembled word |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on return to idle |
| nack_err | output | 1 | Missing acknowledge on address or pointer |

## Verification
A behavioural target on the wired-AND bus decodes START and STOP conditions, returns a word that encodes the pointer and the word index, and logs every acknowledge bit the controller gives. The bench targets several failure modes:
- A design that swaps bytes or bits would return mangled words.
- A design that acknowledges the last byte, or NACKs a middle one, would show up in the acknowledge log.
- A design that inserts a STOP before the repeated START, or re-addresses between words, would change the START and STOP counts.
- A design that stalls or streams after a refused address or pointer would deliver words or leave `nack_err` low.

Further checks cover a zero word count, a start pulse issued mid-transfer, and the SCL rise-to-rise spacing.

// File: rtl/i2cwr_pkg.sv
`timescale 1ns/1ps
package i2cwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_TX, ST_RX, ST_RESTART, ST_STOP
    } st_e;

    typedef enum logic [1:0] {
        TXK_ADDR_W, TXK_PTR, TXK_ADDR_R
    } txk_e;
endpackage

// File: rtl/i2cwr_qtick.sv
`timescale 1ns/1ps
module i2cwr_qtick #(
    parameter int QDIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int QCW = (QDIV < 2) ? 1 : $clog2(QDIV);
    localparam logic [QCW-1:0] LAST = QCW'(QDIV - 1);

    logic [QCW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/i2cwr_shift8.sv
`timescale 1ns/1ps
module i2cwr_shift8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       din,
    output logic [7:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[6:0], din};
    end
endmodule

// File: rtl/i2c_word_reader.sv
`timescale 1ns/1ps
module i2c_word_reader
    import i2cwr_pkg::*;
#(
    parameter int QDIV   = 125,
    parameter int WCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [6:0]        cmd_addr,
    input  logic [2:0]        cmd_ptr,
    input  logic              cmd_ptr_wr,
    input  logic [WCNT_W-1:0] cmd_words,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [15:0]       word_data,
    output logic              word_valid,
    output logic              busy,
    output logic              done,
    output logic              nack_err
);
    localparam logic [3:0]        ACK_BIT = 4'd8;
    localparam logic [WCNT_W-1:0] ONE_W   = WCNT_W'(1);

    st_e               state;
    txk_e              txk;
    logic [1:0]        qtr;
    logic [3:0]        bitn;
    logic [7:0]        tx_byte;
    logic [7:0]        hi_byte;
    logic [7:0]        rx_q;
    logic              rx_hi;
    logic              ack_ok;
    logic              ptr_wr_q;
    logic [6:0]        addr_q;
    logic [2:0]        ptr_q;
    logic [WCNT_W-1:0] words_left;
    logic              qtick;
    logic              last_q;
    logic              rx_en;

    i2cwr_qtick #(.QDIV(QDIV)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == ST_IDLE),
        .tick (qtick)
    );

    assign rx_en = qtick && (qtr == 2'd1) && (state == ST_RX) && (bitn != ACK_BIT);

    i2cwr_shift8 u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (rx_en),
        .din  (sda_in),
        .q    (rx_q)
    );

    assign busy   = (state != ST_IDLE);
    assign last_q = (qtr == 2'd3);

    // State register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            txk        <= TXK_ADDR_W;
            qtr        <= 2'd0;
            bitn       <= 4'd0;
            tx_byte    <= 8'd0;
            hi_byte    <= 8'd0;
            rx_hi      <= 1'b1;
            ack_ok     <= 1'b0;
            ptr_wr_q   <= 1'b0;
            addr_q     <= 7'd0;
            ptr_q      <= 3'd0;
            words_left <= ONE_W;
            word_data  <= 16'd0;
            word_valid <= 1'b0;
            done       <= 1'b0;
            nack_err   <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            done       <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_start) begin
                    addr_q     <= cmd_addr;
                    ptr_q      <= cmd_ptr;
                    ptr_wr_q   <= cmd_ptr_wr;
                    words_left <= (cmd_words == '0) ? ONE_W : cmd_words;
                    nack_err   <= 1'b0;
                    qtr        <= 2'd0;
                    state      <= ST_START;
                end
            end else if (qtick) begin
                qtr <= qtr + 2'd1;
                if (qtr == 2'd1 && state == ST_TX && bitn == ACK_BIT)
                    ack_ok <= !sda_in;
                if (last_q) begin
                    unique case (state)
                        ST_START: begin
                            state   <= ST_TX;
                            bitn    <= 4'd0;
                            txk     <= ptr_wr_q ? TXK_ADDR_W : TXK_ADDR_R;
                            tx_byte <= {addr_q, !ptr_wr_q};
                        end
                        ST_TX: begin
                            if (bitn != ACK_BIT) begin
                                bitn <= bitn + 4'd1;
                            end else if (!ack_ok) begin
                                nack_err <= 1'b1;
                                state    <= ST_STOP;
                            end else begin
                                bitn <= 4'd0;
                                unique case (txk)
                                    TXK_ADDR_W: begin
                                        txk     <= TXK_PTR;
                                        tx_byte <= {5'd0, ptr_q};
                                    end
                                    TXK_PTR:    state <= ST_RESTART;
                                    default: begin
                                        state <= ST_RX;
                                        rx_hi <= 1'b1;
                                    end
                                endcase
                            end
                        end
                        ST_RESTART: begin
                            state   <= ST_TX;
                            bitn    <= 4'd0;
                            txk     <= TXK_ADDR_R;
                            tx_byte <= {addr_q, 1'b1};
                        end
                        ST_RX: begin
                            if (bitn != ACK_BIT) begin
                                bitn <= bitn + 4'd1;
                            end else begin
                                bitn <= 4'd0;
                                if (rx_hi) begin
                                    hi_byte <= rx_q;
                                    rx_hi   <= 1'b0;
                                end else begin
                                    word_data  <= {hi_byte, rx_q};
                                    word_valid <= 1'b1;
                                    rx_hi      <= 1'b1;
                                    if (words_left == ONE_W) state <= ST_STOP;
                                    else words_left <= words_left - ONE_W;
                                end
                            end
                        end
                        ST_STOP: begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // Line outputs per state and quarter
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            ST_START: begin
                scl_oe = (qtr == 2'd3);
                sda_oe = qtr[1];
            end
            ST_RESTART: begin
                scl_oe = (qtr == 2'd0) || (qtr == 2'd3);
                sda_oe = qtr[1];
            end
            ST_STOP: begin
                scl_oe = (qtr == 2'd0);
                sda_oe = !qtr[1];
            end
            ST_TX: begin
                scl_oe = (qtr == 2'd0) || (qtr == 2'd3);
                sda_oe = (bitn != ACK_BIT) && !tx_byte[3'd7 - bitn[2:0]];
            end
            ST_RX: begin
                scl_oe = (qtr == 2'd0) || (qtr == 2'd3);
                sda_oe = (bitn == ACK_BIT) && (rx_hi || (words_left != ONE_W));
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2cwr_checker.sv
`timescale 1ns/1ps
module i2cwr_checker
    import i2cwr_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input st_e  state,
    input logic qtick,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic word_valid,
    input logic nack_err
);
    // R9: data line moves with clock released only in START, RESTART, STOP
    assert_sda_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> (state == ST_START || state == ST_RESTART || state == ST_STOP));

    // R9: clock level changes only at a quarter boundary
    assert_scl_quarter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $past(qtick));

    // R10: idle releases both lines
    assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R10: done is a single-cycle pulse in idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R8: error flag rises only when a STOP is started
    assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_err) |-> (state == ST_STOP));

    // R5: word strobes only inside a transfer, never back to back
    assert_valid_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (busy ##1 !word_valid));
endmodule

bind i2c_word_reader i2cwr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .qtick     (qtick),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .done      (done),
    .word_valid(word_valid),
    .nack_err  (nack_err)
);

// File: tb/i2c_word_reader_test.sv
`timescale 1ns/1ps
module i2c_word_reader_test;
    localparam int         QDIV = 4;
    localparam int         WCW  = 8;
    localparam logic [6:0] TGT  = 7'h4A;
    localparam realtime    BITT = 4.0 * QDIV * 5.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           cmd_start = 1'b0;
    logic [6:0]     cmd_addr = '0;
    logic [2:0]     cmd_ptr = '0;
    logic           cmd_ptr_wr = 1'b0;
    logic [WCW-1:0] cmd_words = '0;
    logic           scl_oe, sda_oe, word_valid, busy, done, nack_err;
    logic [15:0]    word_data;
    logic           t_oe = 1'b0;
    logic           scl_w, sda_w;

    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || t_oe);

    i2c_word_reader #(.QDIV(QDIV), .WCNT_W(WCW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_ptr(cmd_ptr), .cmd_ptr_wr(cmd_ptr_wr), .cmd_words(cmd_words),
        .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe), .word_data(word_data),
        .word_valid(word_valid), .busy(busy), .done(done), .nack_err(nack_err)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %s expected %s", what, got, exp);
        end
    endtask

    function automatic logic [15:0] word_for(input logic [2:0] p, input int n);
        logic [7:0] nb;
        nb = n[7:0];
        return {1'b1, p, nb[3:0], 8'h5A ^ nb};
    endfunction

    // ---------------- behavioural target ----------------
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         t_mode = 0;   // 0 idle, 1 address, 2 pointer, 3 wait restart, 4 read
    int         t_b = 0;
    bit         t_armed = 0;
    logic [7:0] t_sh = '0;
    logic       t_match = 0, t_rw = 0, t_lo = 0, t_mack = 0;
    logic [2:0] t_ptr = '0;
    logic [7:0] t_ptr_byte = '0;
    logic [15:0] t_word = '0;
    int         t_widx = 0;
    bit         t_nack_ptr = 0;
    int         n_start = 0, n_stop = 0, bad_period = 0;
    realtime    prev_rise = -1.0;
    logic       ack_log[$];
    logic [7:0] addr_log[$];

    always @(scl_w or sda_w) begin
        if (scl_w && p_scl && p_sda && !sda_w) begin
            n_start++; t_mode = 1; t_b = 0; t_armed = 1; t_oe = 0; prev_rise = -1.0;
        end else if (scl_w && p_scl && !p_sda && sda_w) begin
            n_stop++; t_mode = 0; t_oe = 0;
        end else if (scl_w && !p_scl) begin
            if (prev_rise >= 0.0) begin
                if (($realtime - prev_rise) > BITT + 0.1 || ($realtime - prev_rise) < BITT - 0.1)
                    bad_period++;
            end
            prev_rise = $realtime;
            if (t_mode != 0) begin
                if (t_b < 8) t_sh = {t_sh[6:0], sda_w};
                else if (t_mode == 4) begin
                    t_mack = !sda_w;
                    ack_log.push_back(!sda_w);
                end
            end
        end else if (!scl_w && p_scl) begin
            if (t_armed) t_armed = 0;
            else if (t_mode != 0) begin
                t_b++;
                if (t_b == 8) begin
                    if (t_mode == 1) begin
                        addr_log.push_back(t_sh);
                        t_match = (t_sh[7:1] == TGT);
                        t_rw = t_sh[0];
                        t_oe = t_match;
                    end else if (t_mode == 2) begin
                        t_ptr_byte = t_sh;
                        if (!t_nack_ptr) t_ptr = t_sh[2:0];
                        t_oe = !t_nack_ptr;
                    end else t_oe = 0;
                end else if (t_b == 9) begin
                    t_b = 0; t_oe = 0;
                    if (t_mode == 1) begin
                        if (!t_match) t_mode = 0;
                        else if (t_rw) begin
                            t_mode = 4; t_lo = 0; t_widx = 0; t_word = word_for(t_ptr, 0);
                        end else t_mode = 2;
                    end else if (t_mode == 2) t_mode = 3;
                    else if (t_mode == 4) begin
                        if (!t_mack) t_mode = 0;
                        else begin
                            if (t_lo) begin t_widx++; t_word = word_for(t_ptr, t_widx); end
                            t_lo = !t_lo;
                        end
                    end
                end
                if (t_mode == 4 && t_b < 8)
                    t_oe = !(t_lo ? t_word[7 - t_b] : t_word[15 - t_b]);
            end
        end
        p_scl = scl_w;
        p_sda = !(sda_oe || t_oe);
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q[$];
    logic [2:0]  exp_ptr = 3'd0;

    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_q.size() == 0)
                chk(0, "R7 unexpected word", $sformatf("%h", word_data), "none");
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(word_data == e, "R5 word value", $sformatf("%h", word_data), $sformatf("%h", e));
            end
        end
    end

    task automatic run(input logic pw, input logic [2:0] p, input int w,
                       input logic [6:0] a, input bit nptr, input bit poke);
        int  n, s0, e0, k0, a0, b0, g, exp_starts;
        bit  ok;
        logic [2:0] rp;
        n  = (w == 0) ? 1 : w;
        ok = (a == TGT) && !(pw && nptr);
        rp = pw ? p : exp_ptr;
        s0 = n_start; e0 = n_stop; k0 = ack_log.size(); a0 = addr_log.size(); b0 = bad_period;
        if (ok) for (int i = 0; i < n; i++) exp_q.push_back(word_for(rp, i));
        if (ok && pw) exp_ptr = p;
        t_nack_ptr = nptr;
        @(negedge clk);
        cmd_addr = a; cmd_ptr = p; cmd_ptr_wr = pw; cmd_words = WCW'(w); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", $sformatf("%b", busy), "1");
        if (poke) begin
            repeat (300) @(negedge clk);
            cmd_addr = 7'h11; cmd_ptr = 3'd6; cmd_ptr_wr = 1'b0; cmd_words = 8'd9; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        g = 0;
        while (!done && g < 20000) begin @(negedge clk); g++; end
        chk(done == 1'b1, "R10 done pulse seen", $sformatf("%b", done), "1");
        chk(busy == 1'b0, "R10 idle at done", $sformatf("%b", busy), "0");
        chk(nack_err == !ok, "R8 nack_err", $sformatf("%b", nack_err), $sformatf("%b", !ok));
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", $sformatf("%b", done), "0");
        chk(!scl_oe && !sda_oe, "R10 lines released", $sformatf("%b%b", scl_oe, sda_oe), "00");
        chk(exp_q.size() == 0, "R7 word count", $sformatf("%0d left", exp_q.size()), "0 left");
        chk(n_stop - e0 == 1, "R4 stop count", $sformatf("%0d", n_stop - e0), "1");
        exp_starts = (pw && a == TGT && !nptr) ? 2 : 1;
        chk(n_start - s0 == exp_starts, "R4 start count", $sformatf("%0d", n_start - s0),
            $sformatf("%0d", exp_starts));
        chk(addr_log.size() > a0 && addr_log[a0] == {a, !pw}, "R1 first address frame",
            $sformatf("%h", (addr_log.size() > a0) ? addr_log[a0] : 8'hxx), $sformatf("%h", {a, !pw}));
        if (!pw && a == TGT)
            chk(addr_log.size() == a0 + 1, "R2 single address frame",
                $sformatf("%0d", addr_log.size() - a0), "1");
        if (pw && a == TGT) begin
            chk(t_ptr_byte == {5'd0, p}, "R3 pointer byte", $sformatf("%h", t_ptr_byte),
                $sformatf("%h", {5'd0, p}));
            if (!nptr)
                chk(addr_log.size() == a0 + 2 && addr_log[a0 + 1] == {a, 1'b1}, "R4 read re-address",
                    $sformatf("%0d frames", addr_log.size() - a0), "2 frames ending in read");
        end
        if (ok) begin
            chk(ack_log.size() - k0 == 2 * n, "R6 data byte count",
                $sformatf("%0d", ack_log.size() - k0), $sformatf("%0d", 2 * n));
            for (int i = k0; i < ack_log.size(); i++)
                chk(ack_log[i] == (i != ack_log.size() - 1), "R6 acknowledge bit",
                    $sformatf("%b", ack_log[i]), $sformatf("%b", i != ack_log.size() - 1));
        end else
            chk(ack_log.size() == k0, "R8 no data after refusal",
                $sformatf("%0d", ack_log.size() - k0), "0");
        chk(bad_period == b0, "R9 SCL bit spacing", $sformatf("%0d bad", bad_period - b0), "0 bad");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !nack_err && !word_valid && !scl_oe && !sda_oe, "R10 reset state",
            $sformatf("%b%b%b%b%b%b", busy, done, nack_err, word_valid, scl_oe, sda_oe), "000000");
        run(1'b1, 3'd5, 3, TGT, 0, 0);        // pointer set, three words
        run(1'b0, 3'd0, 1, TGT, 0, 0);        // preset pointer, one word
        run(1'b1, 3'd2, 2, TGT, 0, 1);        // R11: start pulse while busy is ignored
        run(1'b0, 3'd0, 0, TGT, 0, 0);        // R7: zero count reads one word
        run(1'b0, 3'd0, 2, 7'h13, 0, 0);      // R8: address refused
        run(1'b1, 3'd7, 2, TGT, 1, 0);        // R8: pointer refused
        run(1'b0, 3'd0, 4, TGT, 0, 0);        // R8: next command clears flag
        run(1'b1, 3'd0, 5, TGT, 0, 0);        // pointer zero, long stream
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule